// File: doc/BRIEF.md
# Fetch Group Extractor

This block sits between the buffered instruction line of the thread that fetch has selected and the decode queue. Each accepted request carries one cache line, the thread's current PC and next PC, a translation-fault marker, and slot-indexed branch prediction hints from an external predictor. From that the block cuts out a group of up to `W` fixed 4-byte instructions in program order. For each slot it works out the following PC, either sequential or the predicted target. It stops the group at the end of the line, at the width limit, or right after a predicted redirect. Every emitted instruction takes a number from a global sequence counter.

Two outcomes are special. A designated quiesce word is emitted and ends the group, and the thread then parks in a quiesce-pending state. A faulting request emits a single filler slot that carries the fault flag, and the thread parks in a trap-pending state. A parked thread accepts no request until `resume` is pulsed.

Both sides use valid/ready. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. A group stays on the outputs, unchanged, for as long as `out_valid` is high and `out_ready` is low. `in_ready` is high only when the thread is running and the output register is empty or being drained in that same cycle.

Top module: `fgx`

## Requirements
- R1: The first slot starts at the request PC with bits [1:0] cleared. Its word index in the line is that PC's bits [log2(LINE_BYTES)-1:2]. Emitted instructions fill slots 0 to n-1 in program order, each with PC = aligned start + 4*slot. `out_slot_vld` bit i marks slot i, and the bits of unused slots are 0.
- R2: A group never extends past the last word of the line.
- R3: A group holds at most `W` instructions.
- R4: For slot i, the next PC is `pred_tgt[i]` when `pred_ctrl[i]` and `pred_taken[i]` are both 1, and is PC+4 otherwise. The group ends after the first slot whose next PC differs from PC+4. A taken prediction whose target equals PC+4 does not end the group.
- R5: `out_upd_pc` is the next PC of the last emitted slot. `out_upd_npc` is that value + 4 and `out_upd_nnpc` is that value + 8.
- R6: An instruction equal to `QUIESCE_WORD` is emitted, `out_quiesce` is set, and the group ends at that instruction. `thr_state` becomes 1 (quiesce pending) on the accepting edge and `in_ready` stays 0 until `resume`.
- R7: When `in_fault` is 1, exactly slot 0 is valid and holds `NOP_WORD` with `out_fault` = 1. The update PCs are the request PC, its next PC, and next PC + 4. `thr_state` becomes 2 (trap pending). Requests offered while trap-pending are ignored.
- R8: Slot i of a group carries sequence number base+i. The base of each group is the previous group's base plus the previous group's instruction count, and the counter starts from 0 after reset.
- R9: `out_br_cnt` counts the emitted slots with `pred_ctrl` set, and `out_tk_cnt` counts those that also have `pred_taken` set. A fault group reports 0 for both.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output field holds steady and `in_ready` is 0.
- R11: After reset, `out_valid` is 0, `thr_state` is 0 (running), `in_ready` is 1, and `resume` returns a parked thread to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_line | input | LINE_BYTES*8 | Buffered line, word k at bits [32k+31:32k] |
| in_pc | input | PC_W | Thread current PC |
| in_npc | input | PC_W | Thread next PC |
| in_fault | input | 1 | Translation fault marker for this request |
| pred_ctrl | input | W | Slot i holds a control instruction |
| pred_taken | input | W | Slot i predicted taken |
| pred_tgt | input | W*PC_W | Predicted target for slot i |
| resume | input | 1 | Return a parked thread to running |
| out_valid | output | 1 | Group present |
| out_ready | input | 1 | Decode queue takes the group |
| out_slot_vld | output | W | Per-slot valid |
| out_instr | output | W*32 | Per-slot instruction word |
| out_pc | output | W*PC_W | Per-slot PC |
| out_seq | output | W*SEQ_W | Per-slot sequence number |
| out_fault | output | 1 | Group is a fault filler |
| out_quiesce | output | 1 | Group ended on a quiesce word |
| out_upd_pc | output | PC_W | Thread PC after the group |
| out_upd_npc | output | PC_W | Thread next PC after the group |
| out_upd_nnpc | output | PC_W | Thread next-next PC after the group |
| out_br_cnt | output | $clog2(W+1) | Control slots in the group |
| out_tk_cnt | output | $clog2(W+1) | Predicted-taken slots in the group |
| thr_state | output | 2 | 0 running, 1 quiesce pending, 2 trap pending |

## Verification
The extraction path is driven with line-aligned starts and with starts near the end of the line, so a group cut by width can be told apart from one cut by the line boundary. Prediction patterns cover no branch, a branch predicted not taken, a taken branch mid-group, a taken branch whose target is the fall-through address, two taken branches (only the first counts), a taken branch on the line's last word, and a taken hint on a slot past the line end that must not be counted. Fault, quiesce and stalled-output patterns then separate the parked-thread and back-pressure behaviour from ordinary extraction, and a running sequence tally checks the numbering carries across all of them.

// File: rtl/fgx_pkg.sv
package fgx_pkg;
  typedef enum logic [1:0] {
    THR_RUN   = 2'd0,
    THR_QPEND = 2'd1,
    THR_TRAP  = 2'd2
  } thr_state_t;
endpackage

// File: rtl/fgx_slot_chain.sv
module fgx_slot_chain #(
  parameter int          W            = 4,
  parameter int          LINE_BYTES   = 32,
  parameter int          PC_W         = 32,
  parameter logic [31:0] QUIESCE_WORD = 32'h7FFF_FFF0
) (
  input  logic [LINE_BYTES*8-1:0]     line_data,
  input  logic [PC_W-1:0]             start_pc,
  input  logic [W-1:0]                pred_ctrl,
  input  logic [W-1:0]                pred_taken,
  input  logic [W*PC_W-1:0]           pred_tgt,
  output logic [W-1:0]                slot_vld,
  output logic [W*32-1:0]             slot_instr,
  output logic [W*PC_W-1:0]           slot_pc,
  output logic                        hit_quiesce,
  output logic [PC_W-1:0]             last_next,
  output logic [$clog2(W+1)-1:0]      br_cnt,
  output logic [$clog2(W+1)-1:0]      tk_cnt
);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CNT_W = $clog2(W+1);

  logic [PC_W-1:0] base_pc;
  int              w0;

  assign base_pc = {start_pc[PC_W-1:2], 2'b00};
  assign w0      = int'(base_pc[OFF_W-1:2]);

  // Walk the slots in order; a slot lives while the previous one lived,
  // did not stop the group, and the word is still inside the line.
  always_comb begin
    logic            run;
    int              widx;
    logic            inl;
    logic [PC_W-1:0] pc_i;
    logic [PC_W-1:0] nxt_i;
    logic [31:0]     ins;
    logic            tk;
    logic            alive_i;
    logic            stop_i;
    slot_vld    = '0;
    slot_instr  = '0;
    slot_pc     = '0;
    hit_quiesce = 1'b0;
    last_next   = base_pc + PC_W'(4);
    br_cnt      = '0;
    tk_cnt      = '0;
    run         = 1'b1;
    for (int i = 0; i < W; i++) begin
      widx    = w0 + i;
      inl     = (widx < WORDS);
      pc_i    = base_pc + PC_W'(4 * i);
      ins     = line_data[(inl ? widx : 0) * 32 +: 32];
      tk      = pred_ctrl[i] & pred_taken[i];
      nxt_i   = tk ? pred_tgt[i*PC_W +: PC_W] : pc_i + PC_W'(4);
      stop_i  = (ins == QUIESCE_WORD) || (nxt_i != pc_i + PC_W'(4));
      alive_i = run && inl;
      if (alive_i) begin
        slot_vld[i]                 = 1'b1;
        slot_instr[i*32 +: 32]      = ins;
        slot_pc[i*PC_W +: PC_W]     = pc_i;
        last_next                   = nxt_i;
        if (ins == QUIESCE_WORD) hit_quiesce = 1'b1;
        if (pred_ctrl[i])        br_cnt = br_cnt + CNT_W'(1);
        if (tk)                  tk_cnt = tk_cnt + CNT_W'(1);
      end
      run = alive_i && !stop_i;
    end
  end
endmodule

// File: rtl/fgx_thread_ctl.sv
module fgx_thread_ctl #(
  parameter int W     = 4,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   fault,
  input  logic                   quiesce,
  input  logic [$clog2(W+1)-1:0] count,
  input  logic                   resume,
  output fgx_pkg::thr_state_t    state,
  output logic [SEQ_W-1:0]       seq_base
);
  import fgx_pkg::*;

  thr_state_t       state_q;
  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= THR_RUN;
      seq_q   <= '0;
    end else begin
      if (accept) begin
        seq_q <= seq_q + SEQ_W'(count);
        if (fault)        state_q <= THR_TRAP;
        else if (quiesce) state_q <= THR_QPEND;
      end else if (resume) begin
        state_q <= THR_RUN;
      end
    end
  end

  assign state    = state_q;
  assign seq_base = seq_q;
endmodule

// File: rtl/fgx_out_stage.sv
module fgx_out_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAY_W-1:0] pay_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PAY_W-1:0] pay_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pay_out   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      pay_out   <= pay_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fgx.sv
module fgx #(
  parameter int          W            = 4,
  parameter int          LINE_BYTES   = 32,
  parameter int          PC_W         = 32,
  parameter int          SEQ_W        = 16,
  parameter logic [31:0] QUIESCE_WORD = 32'h7FFF_FFF0,
  parameter logic [31:0] NOP_WORD     = 32'h5A5A_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LINE_BYTES*8-1:0]  in_line,
  input  logic [PC_W-1:0]          in_pc,
  input  logic [PC_W-1:0]          in_npc,
  input  logic                     in_fault,
  input  logic [W-1:0]             pred_ctrl,
  input  logic [W-1:0]             pred_taken,
  input  logic [W*PC_W-1:0]        pred_tgt,
  input  logic                     resume,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [W-1:0]             out_slot_vld,
  output logic [W*32-1:0]          out_instr,
  output logic [W*PC_W-1:0]        out_pc,
  output logic [W*SEQ_W-1:0]       out_seq,
  output logic                     out_fault,
  output logic                     out_quiesce,
  output logic [PC_W-1:0]          out_upd_pc,
  output logic [PC_W-1:0]          out_upd_npc,
  output logic [PC_W-1:0]          out_upd_nnpc,
  output logic [$clog2(W+1)-1:0]   out_br_cnt,
  output logic [$clog2(W+1)-1:0]   out_tk_cnt,
  output logic [1:0]               thr_state
);
  import fgx_pkg::*;

  localparam int CNT_W = $clog2(W+1);
  localparam int PAY_W = W + W*32 + W*PC_W + 2 + 3*PC_W + 2*CNT_W + SEQ_W;

  logic [W-1:0]       c_vld;
  logic [W*32-1:0]    c_instr;
  logic [W*PC_W-1:0]  c_pc;
  logic               c_q;
  logic [PC_W-1:0]    c_next;
  logic [CNT_W-1:0]   c_br, c_tk;

  fgx_slot_chain #(
    .W(W), .LINE_BYTES(LINE_BYTES), .PC_W(PC_W), .QUIESCE_WORD(QUIESCE_WORD)
  ) u_chain (
    .line_data(in_line), .start_pc(in_pc), .pred_ctrl(pred_ctrl),
    .pred_taken(pred_taken), .pred_tgt(pred_tgt), .slot_vld(c_vld),
    .slot_instr(c_instr), .slot_pc(c_pc), .hit_quiesce(c_q),
    .last_next(c_next), .br_cnt(c_br), .tk_cnt(c_tk)
  );

  // Fault overrides extraction with a single filler slot.
  logic [W-1:0]       g_vld;
  logic [W*32-1:0]    g_instr;
  logic [W*PC_W-1:0]  g_pc;
  logic               g_q;
  logic [PC_W-1:0]    g_upc, g_unpc, g_unnpc;
  logic [CNT_W-1:0]   g_br, g_tk, g_cnt;

  always_comb begin
    if (in_fault) begin
      g_vld        = W'(1);
      g_instr      = '0;
      g_instr[31:0] = NOP_WORD;
      g_pc         = '0;
      g_pc[PC_W-1:0] = in_pc;
      g_q          = 1'b0;
      g_upc        = in_pc;
      g_unpc       = in_npc;
      g_unnpc      = in_npc + PC_W'(4);
      g_br         = '0;
      g_tk         = '0;
    end else begin
      g_vld        = c_vld;
      g_instr      = c_instr;
      g_pc         = c_pc;
      g_q          = c_q;
      g_upc        = c_next;
      g_unpc       = c_next + PC_W'(4);
      g_unnpc      = c_next + PC_W'(8);
      g_br         = c_br;
      g_tk         = c_tk;
    end
    g_cnt = CNT_W'($countones(g_vld));
  end

  thr_state_t       st;
  logic [SEQ_W-1:0] seq_base;
  logic             accept;

  assign in_ready = (st == THR_RUN) && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  fgx_thread_ctl #(.W(W), .SEQ_W(SEQ_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .fault(in_fault),
    .quiesce(g_q), .count(g_cnt), .resume(resume),
    .state(st), .seq_base(seq_base)
  );

  logic [PAY_W-1:0] pay_in, pay_out;
  logic [SEQ_W-1:0] out_seq_base;

  assign pay_in = {g_vld, g_instr, g_pc, in_fault, g_q, g_upc, g_unpc, g_unnpc,
                   g_br, g_tk, seq_base};

  fgx_out_stage #(.PAY_W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .pay_in(pay_in),
    .out_ready(out_ready), .out_valid(out_valid), .pay_out(pay_out)
  );

  assign {out_slot_vld, out_instr, out_pc, out_fault, out_quiesce, out_upd_pc,
          out_upd_npc, out_upd_nnpc, out_br_cnt, out_tk_cnt, out_seq_base} = pay_out;

  for (genvar gi = 0; gi < W; gi++) begin : g_seq
    assign out_seq[gi*SEQ_W +: SEQ_W] = out_seq_base + SEQ_W'(gi);
  end

  assign thr_state = st;
endmodule

// File: rtl/fgx_chk.sv
module fgx_chk #(
  parameter int W    = 4,
  parameter int PC_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [W-1:0]           out_slot_vld,
  input logic [W*PC_W-1:0]      out_pc,
  input logic                   out_fault,
  input logic [PC_W-1:0]        out_upd_pc,
  input logic [$clog2(W+1)-1:0] out_br_cnt,
  input logic [$clog2(W+1)-1:0] out_tk_cnt,
  input logic [1:0]             thr_state
);
  // R10: stalled group is held
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pc) &&
      $stable(out_slot_vld) && $stable(out_upd_pc)));

  // R10: no intake while stalled
  p_stall_rdy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6 / R7: parked thread takes nothing
  p_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_state != 2'd0) |-> !in_ready);

  // R1: valid slots are contiguous from slot 0
  p_contig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_slot_vld[0] &&
      ((out_slot_vld & (out_slot_vld + W'(1))) == '0)));

  // R7: fault group is a single slot
  p_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_slot_vld == W'(1)));

  // R9: taken count never exceeds branch count
  p_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tk_cnt <= out_br_cnt));
endmodule

bind fgx fgx_chk #(.W(W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_slot_vld(out_slot_vld), .out_pc(out_pc),
  .out_fault(out_fault), .out_upd_pc(out_upd_pc), .out_br_cnt(out_br_cnt),
  .out_tk_cnt(out_tk_cnt), .thr_state(thr_state)
);

// File: tb/sim_fgx.sv
`timescale 1ns/1ps
module sim_fgx;
  localparam int          W     = 4;
  localparam int          LB    = 32;
  localparam int          PW    = 32;
  localparam int          SW    = 16;
  localparam logic [31:0] QW    = 32'h7FFF_FFF0;
  localparam logic [31:0] NOPW  = 32'h5A5A_0000;

  typedef struct packed {
    logic [31:0] pc;
    logic [3:0]  ctrl;
    logic [3:0]  tkn;
    logic [31:0] tgt;
    logic [3:0]  qidx;   // 15 = no quiesce word in line
    logic [2:0]  cnt;
    logic [31:0] nxt;
    logic [2:0]  br;
    logic [2:0]  tk;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{32'h100, 4'b0000, 4'b0000, 32'h0,   4'd15, 3'd4, 32'h110, 3'd0, 3'd0}, // width cap
    '{32'h118, 4'b0000, 4'b0000, 32'h0,   4'd15, 3'd2, 32'h120, 3'd0, 3'd0}, // line end
    '{32'h11C, 4'b0000, 4'b0000, 32'h0,   4'd15, 3'd1, 32'h120, 3'd0, 3'd0}, // last word
    '{32'h100, 4'b0010, 4'b0010, 32'h200, 4'd15, 3'd2, 32'h200, 3'd1, 3'd1}, // taken mid
    '{32'h100, 4'b0010, 4'b0000, 32'h200, 4'd15, 3'd4, 32'h110, 3'd1, 3'd0}, // not taken
    '{32'h104, 4'b0001, 4'b0001, 32'h108, 4'd15, 3'd4, 32'h114, 3'd1, 3'd1}, // taken to pc+4
    '{32'h100, 4'b0000, 4'b0000, 32'h0,   4'd2,  3'd3, 32'h10C, 3'd0, 3'd0}, // quiesce
    '{32'h102, 4'b0000, 4'b0000, 32'h0,   4'd15, 3'd4, 32'h110, 3'd0, 3'd0}, // misaligned
    '{32'h100, 4'b0101, 4'b0101, 32'h300, 4'd15, 3'd1, 32'h300, 3'd1, 3'd1}, // two taken
    '{32'h114, 4'b0100, 4'b0100, 32'h400, 4'd15, 3'd3, 32'h400, 3'd1, 3'd1}, // taken on last
    '{32'h118, 4'b0100, 4'b0100, 32'h500, 4'd15, 3'd2, 32'h120, 3'd0, 3'd0}  // hint past end
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_fault = 1'b0, resume = 1'b0;
  logic [LB*8-1:0] in_line = '0;
  logic [PW-1:0] in_pc = '0, in_npc = '0;
  logic [W-1:0] pred_ctrl = '0, pred_taken = '0;
  logic [W*PW-1:0] pred_tgt = '0;
  logic out_valid, out_ready = 1'b1, out_fault, out_quiesce;
  logic [W-1:0] out_slot_vld;
  logic [W*32-1:0] out_instr;
  logic [W*PW-1:0] out_pc;
  logic [W*SW-1:0] out_seq;
  logic [PW-1:0] out_upd_pc, out_upd_npc, out_upd_nnpc;
  logic [2:0] out_br_cnt, out_tk_cnt;
  logic [1:0] thr_state;

  always #2 clk = ~clk;

  fgx #(.W(W), .LINE_BYTES(LB), .PC_W(PW), .SEQ_W(SW),
        .QUIESCE_WORD(QW), .NOP_WORD(NOPW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .in_pc(in_pc), .in_npc(in_npc), .in_fault(in_fault),
    .pred_ctrl(pred_ctrl), .pred_taken(pred_taken), .pred_tgt(pred_tgt),
    .resume(resume), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot_vld(out_slot_vld), .out_instr(out_instr), .out_pc(out_pc),
    .out_seq(out_seq), .out_fault(out_fault), .out_quiesce(out_quiesce),
    .out_upd_pc(out_upd_pc), .out_upd_npc(out_upd_npc),
    .out_upd_nnpc(out_upd_nnpc), .out_br_cnt(out_br_cnt),
    .out_tk_cnt(out_tk_cnt), .thr_state(thr_state)
  );

  int checks = 0;
  int errors = 0;
  logic [SW-1:0] seq_exp = '0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LB*8-1:0] mk_line(input logic [3:0] qidx);
    logic [LB*8-1:0] l;
    for (int k = 0; k < LB/4; k++)
      l[k*32 +: 32] = (k == int'(qidx)) ? QW : (32'hA000_0000 | 32'(k));
    return l;
  endfunction

  task automatic do_resume();
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] base;
    int w0;
    logic [W-1:0] mask;
    @(negedge clk);
    in_line = mk_line(v.qidx); in_pc = v.pc; in_npc = v.pc + 4;
    in_fault = 1'b0; pred_ctrl = v.ctrl; pred_taken = v.tkn;
    pred_tgt = {W{v.tgt}}; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    base = {v.pc[31:2], 2'b00};
    w0 = int'(base[4:2]);
    mask = W'((1 << v.cnt) - 1);
    chk(out_valid, "R1 out_valid", 64'(out_valid), 1);
    chk(out_slot_vld == mask, "R2/R3 slot mask", 64'(out_slot_vld), 64'(mask));
    for (int i = 0; i < W; i++) begin
      if (i < int'(v.cnt)) begin
        logic [31:0] ew;
        ew = (w0 + i == int'(v.qidx)) ? QW : (32'hA000_0000 | 32'(w0 + i));
        chk(out_pc[i*PW +: PW] == base + 32'(4*i), "R1 slot pc",
            64'(out_pc[i*PW +: PW]), 64'(base + 32'(4*i)));
        chk(out_instr[i*32 +: 32] == ew, "R1 slot instr",
            64'(out_instr[i*32 +: 32]), 64'(ew));
        chk(out_seq[i*SW +: SW] == seq_exp + SW'(i), "R8 seq",
            64'(out_seq[i*SW +: SW]), 64'(seq_exp + SW'(i)));
      end
    end
    chk(out_upd_pc == v.nxt, "R4/R5 upd_pc", 64'(out_upd_pc), 64'(v.nxt));
    chk(out_upd_npc == v.nxt + 4, "R5 upd_npc", 64'(out_upd_npc), 64'(v.nxt + 4));
    chk(out_upd_nnpc == v.nxt + 8, "R5 upd_nnpc", 64'(out_upd_nnpc), 64'(v.nxt + 8));
    chk(out_br_cnt == v.br, "R9 br_cnt", 64'(out_br_cnt), 64'(v.br));
    chk(out_tk_cnt == v.tk, "R9 tk_cnt", 64'(out_tk_cnt), 64'(v.tk));
    chk(out_quiesce == (v.qidx != 4'd15), "R6 quiesce flag",
        64'(out_quiesce), 64'(v.qidx != 4'd15));
    chk(thr_state == ((v.qidx != 4'd15) ? 2'd1 : 2'd0), "R6 thread state",
        64'(thr_state), 64'((v.qidx != 4'd15) ? 1 : 0));
    seq_exp = seq_exp + SW'(v.cnt);
    if (thr_state != 2'd0) begin
      chk(!in_ready, "R6 parked not ready", 64'(in_ready), 0);
      do_resume();
      chk(thr_state == 2'd0, "R11 resume", 64'(thr_state), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!out_valid, "R11 out_valid", 64'(out_valid), 0);
    chk(thr_state == 2'd0, "R11 thr_state", 64'(thr_state), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R11 in_ready", 64'(in_ready), 1);

    for (int n = 0; n < NV; n++) run_vec(TBL[n]);

    // R7: translation fault
    @(negedge clk);
    in_line = mk_line(4'd15); in_pc = 32'h140; in_npc = 32'h144;
    in_fault = 1'b1; pred_ctrl = '1; pred_taken = '1; pred_tgt = {W{32'h900}};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_fault = 1'b0;
    chk(out_valid && out_fault, "R7 fault flag", 64'(out_fault), 1);
    chk(out_slot_vld == 4'b0001, "R7 single slot", 64'(out_slot_vld), 1);
    chk(out_instr[31:0] == NOPW, "R7 filler word", 64'(out_instr[31:0]), 64'(NOPW));
    chk(out_upd_pc == 32'h140 && out_upd_npc == 32'h144 && out_upd_nnpc == 32'h148,
        "R7 pc kept", 64'(out_upd_pc), 64'h140);
    chk(out_br_cnt == 0 && out_tk_cnt == 0, "R9 fault counts", 64'(out_br_cnt), 0);
    chk(out_seq[SW-1:0] == seq_exp, "R8 fault seq", 64'(out_seq[SW-1:0]), 64'(seq_exp));
    chk(thr_state == 2'd2, "R7 trap state", 64'(thr_state), 2);
    seq_exp = seq_exp + 1;
    // R7: request while trap-pending is ignored
    in_pc = 32'h180; in_npc = 32'h184; pred_ctrl = '0; pred_taken = '0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R7 ignored while trapped", 64'(out_valid), 0);
    do_resume();
    chk(thr_state == 2'd0, "R11 resume from trap", 64'(thr_state), 0);

    // R10: back-pressure
    out_ready = 1'b0;
    @(negedge clk);
    in_line = mk_line(4'd15); in_pc = 32'h108; in_npc = 32'h10C;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_pc[PW-1:0] == 32'h108, "R10 group out",
        64'(out_pc[PW-1:0]), 64'h108);
    chk(!in_ready, "R10 not ready while stalled", 64'(in_ready), 0);
    in_pc = 32'h1F0;
    repeat (2) @(negedge clk);
    chk(out_valid && out_pc[PW-1:0] == 32'h108 && out_slot_vld == 4'b1111,
        "R10 held", 64'(out_pc[PW-1:0]), 64'h108);
    chk(out_seq[SW-1:0] == seq_exp, "R8 seq after ignored request",
        64'(out_seq[SW-1:0]), 64'(seq_exp));
    seq_exp = seq_exp + 4;
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R10 drained", 64'(out_valid), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule